// File: doc/BRIEF.md
# Chopping Decay-Mode Sequencer

This block decides, cycle by cycle, how one H-bridge winding is driven inside a fixed-frequency constant-current chopping loop. A free-running counter splits time into chopping periods of `PERIOD_CLKS` system clocks. An asynchronous comparator flag reports whether the coil current is below the set current. The flag passes through a two-flop synchroniser before any decision uses it. The block outputs a one-hot mode: charge, slow decay or fast decay.

Each period opens with a forced charge window and closes with a forced fast-decay window. Each window lasts one eighth of the period. Between the two windows, the path depends on what the comparator showed while the bridge was charging:

- If the coil was seen below target, charging continues until the current reaches the set point. The bridge then holds slow decay until the closing window.
- If the coil was never seen below target, the bridge falls straight into fast decay for the rest of the period.

Clearing the channel enable turns every output off and holds the counter at the start of a period.

Top module: `chop_mode_ctrl`

## Requirements
- R1: While `chan_en` is low, `mode_o` is 3'b000 and the period counter is held at zero, so the cycle in which `chan_en` is first seen high is cycle 0 of a fresh period.
- R2: `mode_o` is one-hot while enabled: bit 0 = charge, bit 1 = slow decay, bit 2 = fast decay.
- R3: Cycles 0 to `PERIOD_CLKS`/8 − 1 of every period are charge, whatever the comparator shows.
- R4: The last `PERIOD_CLKS`/8 cycles of every period are fast decay, whatever the comparator shows.
- R5: The period repeats every `PERIOD_CLKS` cycles while enabled.
- R6: When the synchronised flag shows the coil below target during charge, and it is still below target at the end of the opening window, charge continues. Charge ends in the cycle after the synchronised flag first shows the coil at or above target.
- R7: Once slow decay is entered, it persists until the closing fast-decay window, whatever the comparator does.
- R8: If the synchronised flag never shows the coil below target during the charge cycles of a period, the mode is fast decay from the end of the opening window to the end of the period.
- R9: The comparator input reaches the decision logic through exactly two flip-flops. The value driven during cycle k therefore steers the mode of cycle k+3.
- R10: If the coil was seen below target earlier in the opening window but is not below target in its last cycle, the mode moves directly to slow decay when the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; low forces all-off and restarts the period |
| coil_below | input | 1 | Asynchronous comparator flag, high when coil current is below the set current |
| mode_o | output | 3 | One-hot drive mode: bit 0 charge, bit 1 slow decay, bit 2 fast decay |

## Verification
The bench runs a 16-clock period against a cycle-exact model computed in the bench. It uses the following comparator patterns:

- **Constant levels.** Steady not-below and steady below separate the direct-to-fast branch from charge that lasts until the closing window.
- **Step sweep.** A flag that is below target for the first t cycles of each period is swept over every t. This locates the exact end of charge, covering the synchroniser delay and the slow-versus-fast choice at the window boundary.
- **Single-cycle pulses.** A pulse placed at each position in the period shows that a brief dip seen only inside the opening window still selects slow decay, and that a dip arriving after slow decay has begun changes nothing.
- **Pseudo-random run.** A long sequence with random disables and one mid-run reset exercises counter restart and the all-off state.

// File: rtl/chop_pkg.sv
// Shared encodings for the chopping decay-mode sequencer.
// Assumes the mode output is consumed as a one-hot bridge command.
package chop_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'b000,
        MODE_CHARGE = 3'b001,
        MODE_SLOW   = 3'b010,
        MODE_FAST   = 3'b100
    } chop_mode_e;

endpackage

// File: rtl/chop_sync.sv
// Multi-flop synchroniser for a single asynchronous level.
// Assumes STAGES >= 2; output resets to 0 (coil not below target).
module chop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/chop_period_cnt.sv
// Chopping period counter with opening/closing window flags.
// Assumes PERIOD_CLKS is a multiple of 8 and at least 16.
// The counter is held at zero while run_i is low.
module chop_period_cnt #(
    parameter int PERIOD_CLKS = 64,
    parameter int CW          = $clog2(PERIOD_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          head_o,
    output logic          tail_o,
    output logic          last_o
);

    localparam int            WIN       = PERIOD_CLKS / 8;
    localparam logic [CW-1:0] LAST_C    = CW'(PERIOD_CLKS - 1);
    localparam logic [CW-1:0] WIN_C     = CW'(WIN);
    localparam logic [CW-1:0] TAIL_C    = CW'(PERIOD_CLKS - WIN);

    logic [CW-1:0] cnt_q;

    // Advance through the period, wrapping at the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)    cnt_q <= '0;
        else if (cnt_q == LAST_C) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign head_o = (cnt_q < WIN_C);
    assign tail_o = (cnt_q >= TAIL_C);
    assign last_o = (cnt_q == LAST_C);

endmodule

// File: rtl/chop_decay_seq.sv
// Decay-mode decision for the body of a chopping period.
// Forced windows override the body state. The body state tracks whether
// the coil was seen below target while charging.
// Assumes below_i is already synchronous to clk.
module chop_decay_seq
    import chop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       head_i,
    input  logic       tail_i,
    input  logic       last_i,
    input  logic       below_i,
    output chop_mode_e mode_o
);

    chop_mode_e body_q;
    logic       seen_q;
    chop_mode_e cur_mode;
    chop_mode_e body_d;

    // Select the mode for this cycle from the windows and the body state.
    always_comb begin
        if (!run_i)      cur_mode = MODE_OFF;
        else if (head_i) cur_mode = MODE_CHARGE;
        else if (tail_i) cur_mode = MODE_FAST;
        else             cur_mode = body_q;
    end

    // Choose the next body state from the current mode and comparator.
    always_comb begin
        unique case (cur_mode)
            MODE_CHARGE: begin
                if (below_i)     body_d = MODE_CHARGE;
                else if (seen_q) body_d = MODE_SLOW;
                else             body_d = MODE_FAST;
            end
            MODE_SLOW: body_d = MODE_SLOW;
            MODE_FAST: body_d = MODE_FAST;
            default:   body_d = MODE_CHARGE;
        endcase
    end

    // Register the body state; restart it at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || last_i) begin
            body_q <= MODE_CHARGE;
            seen_q <= 1'b0;
        end else begin
            body_q <= body_d;
            seen_q <= seen_q | ((cur_mode == MODE_CHARGE) & below_i);
        end
    end

    assign mode_o = cur_mode;

endmodule

// File: rtl/chop_mode_ctrl.sv
// Top of the chopping decay-mode sequencer for one winding.
// Assumes PERIOD_CLKS is a multiple of 8 and at least 16.
// coil_below may change at any time.
module chop_mode_ctrl #(
    parameter int PERIOD_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       coil_below,
    output logic [2:0] mode_o
);

    import chop_pkg::*;

    localparam int SYNC_STAGES = 2;
    localparam int CW          = $clog2(PERIOD_CLKS);

    logic [CW-1:0] cnt_w;
    logic          head_w;
    logic          tail_w;
    logic          last_w;
    logic          below_sync;
    chop_mode_e    mode_w;

    chop_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (coil_below),
        .sync_o  (below_sync)
    );

    chop_period_cnt #(.PERIOD_CLKS(PERIOD_CLKS), .CW(CW)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (chan_en),
        .cnt_o  (cnt_w),
        .head_o (head_w),
        .tail_o (tail_w),
        .last_o (last_w)
    );

    chop_decay_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (chan_en),
        .head_i  (head_w),
        .tail_i  (tail_w),
        .last_i  (last_w),
        .below_i (below_sync),
        .mode_o  (mode_w)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/chop_mode_ctrl_chk.sv
// Property checker for chop_mode_ctrl, attached with bind.
module chop_mode_ctrl_chk #(
    parameter int PERIOD_CLKS = 64,
    parameter int CW          = $clog2(PERIOD_CLKS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chan_en,
    input logic          coil_below,
    input logic [2:0]    mode_o,
    input logic [CW-1:0] cnt,
    input logic          below_s
);

    localparam int            WIN      = PERIOD_CLKS / 8;
    localparam logic [CW-1:0] LAST_C   = CW'(PERIOD_CLKS - 1);
    localparam logic [CW-1:0] WIN_C    = CW'(WIN);
    localparam logic [CW-1:0] TAIL_C   = CW'(PERIOD_CLKS - WIN);
    localparam logic [CW-1:0] PRETAIL  = CW'(PERIOD_CLKS - WIN - 1);

    logic [1:0] age_q;

    // Count clocks since reset, saturating at two, to qualify history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> mode_o == 3'b000);
    a_r1_counter_held: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> cnt == '0);
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |-> $countones(mode_o) == 1);
    a_r3_head_charge: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && cnt < WIN_C) |-> mode_o == 3'b001);
    a_r4_tail_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && cnt >= TAIL_C) |-> mode_o == 3'b100);
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && cnt == LAST_C) |=> cnt == '0);
    a_r6_charge_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && mode_o[0] && below_s && cnt >= WIN_C - 1'b1 && cnt < PRETAIL)
        |=> (!chan_en || mode_o[0]));
    a_r7_slow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && mode_o[1] && cnt < PRETAIL) |=> (!chan_en || mode_o[1]));
    a_r8_fast_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && mode_o[2] && cnt != LAST_C) |=> (!chan_en || mode_o[2]));
    a_r9_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> below_s == $past(coil_below, 2));

endmodule

bind chop_mode_ctrl chop_mode_ctrl_chk #(.PERIOD_CLKS(PERIOD_CLKS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .coil_below (coil_below),
    .mode_o     (mode_o),
    .cnt        (cnt_w),
    .below_s    (below_sync)
);

// File: tb/chop_mode_ctrl_tb_top.sv
// Bench for chop_mode_ctrl with a 16-clock chopping period.
// Every cycle is compared with a model built from the requirements.
module chop_mode_ctrl_tb_top;

    localparam int N = 16;
    localparam int H = N / 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       coil_below = 1'b0;
    logic [2:0] mode_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Model state: synchroniser flops, period position, body mode, seen flag.
    bit         m_s1, m_s2, m_seen;
    int         m_cnt;
    logic [2:0] m_body = 3'b001;

    always #5 clk = ~clk;

    chop_mode_ctrl #(.PERIOD_CLKS(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .coil_below (coil_below),
        .mode_o     (mode_o)
    );

    function automatic logic [2:0] exp_mode();
        if (!chan_en)      return 3'b000;
        if (m_cnt < H)     return 3'b001;
        if (m_cnt >= N - H) return 3'b100;
        return m_body;
    endfunction

    function automatic string tag_for(logic [2:0] e);
        if (!chan_en)       return "R1";
        if (m_cnt < H)      return "R3/R5";
        if (m_cnt >= N - H) return "R4";
        if (e == 3'b010)    return "R7/R10";
        if (e == 3'b001)    return "R6/R9";
        return "R8";
    endfunction

    // Compare the output of the current cycle with the model.
    task automatic check_cycle();
        logic [2:0] e;
        e = exp_mode();
        n_chk++;
        if (mode_o !== e) begin
            n_fail++;
            $display("FAIL %s cnt=%0d mode actual=%b expected=%b", tag_for(e), m_cnt, mode_o, e);
        end
        if (chan_en) begin
            n_chk++;
            if ($countones(mode_o) != 1) begin
                n_fail++;
                $display("FAIL R2 onehot actual=%b expected one bit set", mode_o);
            end
        end
    endtask

    // Advance the model across one rising edge with the inputs now applied.
    task automatic model_edge();
        logic [2:0] cur;
        logic [2:0] nb;
        cur = exp_mode();
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_cnt = 0; m_body = 3'b001; m_seen = 0;
        end else begin
            if (cur == 3'b001)      nb = m_s2 ? 3'b001 : (m_seen ? 3'b010 : 3'b100);
            else if (cur == 3'b010) nb = 3'b010;
            else                    nb = 3'b100;
            if (!chan_en || m_cnt == N - 1) begin
                m_body = 3'b001; m_seen = 0;
            end else begin
                m_seen = m_seen | ((cur == 3'b001) & m_s2);
                m_body = nb;
            end
            m_cnt = (!chan_en || m_cnt == N - 1) ? 0 : m_cnt + 1;
            m_s2  = m_s1;
            m_s1  = coil_below;
        end
    endtask

    task automatic step(bit rst, bit en, bit raw);
        @(negedge clk);
        check_cycle();
        rst_n = rst; chan_en = en; coil_below = raw;
        model_edge();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // Reset, then enable low: all-off (R1).
        for (int i = 0; i < 4; i++) step(0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 1);
        // Never below: straight to fast decay (R8).
        for (int i = 0; i < 3 * N; i++) step(1, 1, 0);
        step(1, 0, 0);
        // Always below: charge until the closing window (R6).
        for (int i = 0; i < 3 * N; i++) step(1, 1, 1);
        // Step sweep: below for the first t cycles of each period (R6, R9, R10).
        for (int t = 0; t <= N + 1; t++) begin
            step(1, 0, 0); step(1, 0, 0);
            for (int i = 0; i < 2 * N; i++) step(1, 1, (i % N) < t);
        end
        // Single-cycle dips at each position (R7, R10).
        for (int j = 0; j < N; j++) begin
            step(1, 0, 0);
            for (int i = 0; i < 2 * N; i++) step(1, 1, (i % N) == j);
        end
        // Pseudo-random comparator with random disables and one reset (R1, R5).
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i == 1500) step(0, 0, 0);
            else           step(1, lfsr[15:12] != 4'd0, lfsr[0]);
        end
        step(1, 0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule